// File: doc/BRIEF.md
# ADC Conversion Sequencer with Threshold Compare

This block is the digital control around an analog-to-digital converter. Software reaches it over a simple byte-wide register bus. A conversion starts in one of two ways. It can start from a write to the channel register, or from a rising edge on a hardware trigger input. A one-bit control field picks which of the two is used. The block drives a start pulse and a channel number to the converter, and it holds a conversion-active flag until the converter reports done or software aborts the conversion.

Each completed result can go through a threshold compare against a programmable value. The compare can be turned off. When it is on, it accepts results that are below the value, or results that are at or above the value, depending on a polarity bit. Accepted results go into a small result FIFO, which software drains by reading the result registers. A status byte reports the active flag, the three control fields, and the FIFO empty and full flags.

Top module: `adc_seq_ctrl`

Register map: 0x10 is the channel register. 0x11 is the status/control byte. 0x13 holds compare value bits 11:8 and 0x14 holds bits 7:0. 0x15 holds result bits 11:8 (peek only) and 0x16 holds result bits 7:0 (a read pops one entry).

## Requirements
- R1: After reset the status byte at 0x11 reads 0x08, and the compare registers at 0x13 and 0x14 read 0x00. In the status byte, bit 7 is active, bit 6 is hardware trigger select, bit 5 is compare enable, bit 4 is greater-or-equal select, bit 3 is FIFO empty and bit 2 is FIFO full.
- R2: A write to 0x11 updates only bits 6 to 4. Bits 7, 3 and 2 are status bits and keep their value whatever data is written.
- R3: With bit 6 at 0, a write to 0x10 while idle sets active. One clock later the block drives conv_start high for exactly one cycle, and conv_chan carries bits 4:0 of the written data.
- R4: With bit 6 at 1, a write to 0x10 while idle does not start a conversion. A rising edge on hw_trig does start one, and holding hw_trig high does not start another.
- R5: While active, neither a hw_trig rising edge nor a trigger of any kind produces another conv_start.
- R6: conv_done while active clears active. conv_done while idle is ignored and adds nothing to the FIFO.
- R7: A write to 0x10 while active aborts the conversion. It clears active, pulses conv_abort for one cycle, and throws away any later result of that conversion.
- R8: With bit 5 at 0, every completed result enters the FIFO.
- R9: With bit 5 at 1 and bit 4 at 0, a result enters the FIFO only if it is strictly less than the compare value.
- R10: With bit 5 at 1 and bit 4 at 1, a result enters the FIFO only if it is greater than or equal to the compare value.
- R11: The FIFO holds 4 entries and returns them in arrival order. Reading 0x16 returns bits 7:0 of the oldest entry and pops it. Reading 0x15 returns bits 11:8 without popping. Empty and full track the entry count.
- R12: An accepted result that arrives while the FIFO is full is dropped. Full stays at 1 and the stored entries are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_rdata | output | 8 | Read data, combinational from address |
| hw_trig | input | 1 | Hardware trigger, active on its rising edge |
| conv_start | output | 1 | One-cycle start pulse to the converter |
| conv_abort | output | 1 | One-cycle abort pulse to the converter |
| conv_chan | output | 5 | Channel to convert |
| conv_done | input | 1 | Converter reports that a result is ready |
| conv_result | input | 12 | Converter result, valid with conv_done |

## Verification
The hardest case to reach is an accepted result arriving while the FIFO is already full. The bench reaches it by leaving the FIFO undrained while it runs conversions under both compare polarities. Some of those values are chosen to fail the compare and some to pass it, so exactly four entries are taken before a fifth passing value is offered. A second hard case is a late conv_done after an abort. The bench produces it by writing the channel register in mid-conversion and then returning a result.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
   localparam int ST_ACTIVE = 7;
   localparam int ST_TRIG   = 6;
   localparam int ST_CMPEN  = 5;
   localparam int ST_CMPGE  = 4;
   localparam int ST_EMPTY  = 3;
   localparam int ST_FULL   = 2;

   typedef struct packed {
      logic trig_hw;
      logic cmp_en;
      logic cmp_ge;
   } adc_ctrl_t;

   typedef enum logic {
      CONV_IDLE = 1'b0,
      CONV_BUSY = 1'b1
   } conv_state_e;
endpackage

// File: rtl/adc_seq_compare.sv
module adc_seq_compare #(
   parameter int DATA_W      = 12,
   parameter bit HAS_COMPARE = 1'b1
) (
   input  logic              cmp_en,
   input  logic              cmp_ge,
   input  logic [DATA_W-1:0] cmp_value,
   input  logic [DATA_W-1:0] sample,
   output logic              pass
);
   if (DATA_W < 1) begin : g_bad_width
      $error("adc_seq_compare: DATA_W must be positive");
   end

   if (HAS_COMPARE) begin : g_cmp
      logic below;
      assign below = (sample < cmp_value);
      always_comb begin
         if (!cmp_en)      pass = 1'b1;
         else if (cmp_ge)  pass = ~below;
         else              pass = below;
      end
   end else begin : g_nocmp
      assign pass = 1'b1;
   end
endmodule

// File: rtl/adc_seq_fifo.sv
module adc_seq_fifo #(
   parameter int DATA_W = 12,
   parameter int DEPTH  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic [DATA_W-1:0] push_data,
   input  logic              pop,
   output logic [DATA_W-1:0] head,
   output logic              empty,
   output logic              full
);
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CNT_W = PTR_W + 1;

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("adc_seq_fifo: DEPTH must be a power of two, at least 2");
   end

   logic [DATA_W-1:0] store [DEPTH];
   logic [PTR_W-1:0]  wr_ptr, rd_ptr;
   logic [CNT_W-1:0]  count;
   logic              push_ok, pop_ok;

   assign empty   = (count == '0);
   assign full    = (count == CNT_W'(DEPTH));
   assign pop_ok  = pop & ~empty;
   assign push_ok = push & (~full | pop_ok);
   assign head    = store[rd_ptr];

   always_ff @(posedge clk) begin
      if (push_ok) store[wr_ptr] <= push_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (push_ok) wr_ptr <= wr_ptr + 1'b1;
         if (pop_ok)  rd_ptr <= rd_ptr + 1'b1;
         case ({push_ok, pop_ok})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   assert_no_overflow_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (full && push && !pop) |=> (full && $stable(wr_ptr)));
   assert_no_underflow_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (empty && pop && !push) |=> (empty && $stable(rd_ptr)));
   assert_count_bound_R11: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CNT_W'(DEPTH));
endmodule

// File: rtl/adc_seq_conv_fsm.sv
module adc_seq_conv_fsm import adc_seq_pkg::*; (
   input  logic      clk,
   input  logic      rst_n,
   input  adc_ctrl_t ctrl,
   input  logic      chan_wr,
   input  logic      hw_trig,
   input  logic      conv_done,
   output logic      active,
   output logic      conv_start,
   output logic      conv_abort,
   output logic      result_take
);
   conv_state_e state;
   logic        trig_q, trig_rise;
   logic        start_sw, start_hw, start_any, abort_now;

   assign trig_rise   = hw_trig & ~trig_q;
   assign active      = (state == CONV_BUSY);
   assign start_sw    = chan_wr & ~ctrl.trig_hw & ~active;
   assign start_hw    = trig_rise & ctrl.trig_hw & ~active;
   assign start_any   = start_sw | start_hw;
   assign abort_now   = chan_wr & active;
   assign result_take = active & conv_done & ~abort_now;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= CONV_IDLE;
         trig_q     <= 1'b0;
         conv_start <= 1'b0;
         conv_abort <= 1'b0;
      end else begin
         trig_q     <= hw_trig;
         conv_start <= start_any;
         conv_abort <= abort_now;
         if (start_any)                      state <= CONV_BUSY;
         else if (abort_now || result_take)  state <= CONV_IDLE;
      end
   end

   assert_start_when_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
      conv_start |-> active);
   assert_hw_mode_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl.trig_hw && chan_wr && !active && !trig_rise) |=> !conv_start);
   assert_busy_no_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
      active |=> !conv_start);
   assert_done_to_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (active && conv_done && !chan_wr) |=> !active);
   assert_abort_to_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (active && chan_wr) |=> (!active && conv_abort));
endmodule

// File: rtl/adc_seq_regs.sv
module adc_seq_regs import adc_seq_pkg::*; #(
   parameter int         DATA_W    = 12,
   parameter int         CHAN_W    = 5,
   parameter logic [7:0] CHAN_ADDR = 8'h10,
   parameter logic [7:0] STAT_ADDR = 8'h11,
   parameter logic [7:0] CMPH_ADDR = 8'h13,
   parameter logic [7:0] CMPL_ADDR = 8'h14,
   parameter logic [7:0] RESH_ADDR = 8'h15,
   parameter logic [7:0] RESL_ADDR = 8'h16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [7:0]        bus_addr,
   input  logic [7:0]        bus_wdata,
   input  logic              bus_wr,
   input  logic              bus_rd,
   output logic [7:0]        bus_rdata,
   input  logic              active,
   input  logic              fifo_empty,
   input  logic              fifo_full,
   input  logic [DATA_W-1:0] fifo_head,
   output adc_ctrl_t         ctrl,
   output logic [DATA_W-1:0] cmp_value,
   output logic [CHAN_W-1:0] chan,
   output logic              chan_wr,
   output logic              pop_req
);
   localparam int HI_W  = DATA_W - 8;
   localparam int PAD_W = 16 - DATA_W;

   if (DATA_W < 9 || DATA_W > 16) begin : g_bad_width
      $error("adc_seq_regs: DATA_W must lie in 9..16");
   end
   if (CHAN_W < 1 || CHAN_W > 8) begin : g_bad_chan
      $error("adc_seq_regs: CHAN_W must lie in 1..8");
   end

   logic [7:0] status_byte;

   assign chan_wr = bus_wr & (bus_addr == CHAN_ADDR);
   assign pop_req = bus_rd & (bus_addr == RESL_ADDR);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl      <= '0;
         cmp_value <= '0;
         chan      <= '0;
      end else if (bus_wr) begin
         if (bus_addr == STAT_ADDR) begin
            ctrl.trig_hw <= bus_wdata[ST_TRIG];
            ctrl.cmp_en  <= bus_wdata[ST_CMPEN];
            ctrl.cmp_ge  <= bus_wdata[ST_CMPGE];
         end
         if (bus_addr == CMPH_ADDR) cmp_value[DATA_W-1:8] <= bus_wdata[HI_W-1:0];
         if (bus_addr == CMPL_ADDR) cmp_value[7:0]        <= bus_wdata;
         if (chan_wr)               chan                  <= bus_wdata[CHAN_W-1:0];
      end
   end

   always_comb begin
      status_byte            = '0;
      status_byte[ST_ACTIVE] = active;
      status_byte[ST_TRIG]   = ctrl.trig_hw;
      status_byte[ST_CMPEN]  = ctrl.cmp_en;
      status_byte[ST_CMPGE]  = ctrl.cmp_ge;
      status_byte[ST_EMPTY]  = fifo_empty;
      status_byte[ST_FULL]   = fifo_full;
   end

   always_comb begin
      case (bus_addr)
         CHAN_ADDR: bus_rdata = 8'(chan);
         STAT_ADDR: bus_rdata = status_byte;
         CMPH_ADDR: bus_rdata = {{PAD_W{1'b0}}, cmp_value[DATA_W-1:8]};
         CMPL_ADDR: bus_rdata = cmp_value[7:0];
         RESH_ADDR: bus_rdata = {{PAD_W{1'b0}}, fifo_head[DATA_W-1:8]};
         RESL_ADDR: bus_rdata = fifo_head[7:0];
         default:   bus_rdata = 8'h00;
      endcase
   end

   assert_ctrl_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == STAT_ADDR) |=> (ctrl == $past(bus_wdata[6:4])));
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl import adc_seq_pkg::*; #(
   parameter int DATA_W      = 12,
   parameter int CHAN_W      = 5,
   parameter int FIFO_DEPTH  = 4,
   parameter bit HAS_COMPARE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [7:0]        bus_addr,
   input  logic [7:0]        bus_wdata,
   input  logic              bus_wr,
   input  logic              bus_rd,
   output logic [7:0]        bus_rdata,
   input  logic              hw_trig,
   output logic              conv_start,
   output logic              conv_abort,
   output logic [CHAN_W-1:0] conv_chan,
   input  logic              conv_done,
   input  logic [DATA_W-1:0] conv_result
);
   adc_ctrl_t         ctrl;
   logic [DATA_W-1:0] cmp_value, fifo_head;
   logic              chan_wr, pop_req, active, result_take, cmp_pass;
   logic              fifo_push, fifo_empty, fifo_full;

   adc_seq_regs #(.DATA_W(DATA_W), .CHAN_W(CHAN_W)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_wr(bus_wr),
      .bus_rd(bus_rd), .bus_rdata(bus_rdata),
      .active(active), .fifo_empty(fifo_empty), .fifo_full(fifo_full),
      .fifo_head(fifo_head), .ctrl(ctrl), .cmp_value(cmp_value),
      .chan(conv_chan), .chan_wr(chan_wr), .pop_req(pop_req)
   );

   adc_seq_conv_fsm u_fsm (
      .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .chan_wr(chan_wr),
      .hw_trig(hw_trig), .conv_done(conv_done), .active(active),
      .conv_start(conv_start), .conv_abort(conv_abort),
      .result_take(result_take)
   );

   adc_seq_compare #(.DATA_W(DATA_W), .HAS_COMPARE(HAS_COMPARE)) u_cmp (
      .cmp_en(ctrl.cmp_en), .cmp_ge(ctrl.cmp_ge), .cmp_value(cmp_value),
      .sample(conv_result), .pass(cmp_pass)
   );

   assign fifo_push = result_take & cmp_pass;

   adc_seq_fifo #(.DATA_W(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk(clk), .rst_n(rst_n), .push(fifo_push), .push_data(conv_result),
      .pop(pop_req), .head(fifo_head), .empty(fifo_empty), .full(fifo_full)
   );

   assert_push_needs_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_push |-> (conv_done && active));
   assert_cmp_off_takes_all_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (result_take && !ctrl.cmp_en) |-> fifo_push);
endmodule

// File: tb/adc_seq_ctrl_test.sv
module adc_seq_ctrl_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_addr = '0, bus_wdata = '0, bus_rdata;
   logic        bus_wr = 1'b0, bus_rd = 1'b0, hw_trig = 1'b0;
   logic        conv_start, conv_abort, conv_done = 1'b0;
   logic [4:0]  conv_chan;
   logic [11:0] conv_result = '0;

   int n_checks = 0, n_fail = 0;
   logic [11:0] exp_q[$];
   bit   m_en = 0, m_ge = 0;
   logic [11:0] m_cmp = '0;

   always #2.5 clk = ~clk;

   adc_seq_ctrl uut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
      .hw_trig(hw_trig), .conv_start(conv_start), .conv_abort(conv_abort),
      .conv_chan(conv_chan), .conv_done(conv_done), .conv_result(conv_result)
   );

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(logic [7:0] a, logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(logic [7:0] a, output logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic set_ctrl(bit hw, bit en, bit ge);
      m_en = en; m_ge = ge;
      wr(8'h11, {1'b1, hw, en, ge, 4'hF});
   endtask

   // driver: returns a result; scoreboard model decides acceptance
   task automatic finish_conv(logic [11:0] v);
      bit pass;
      pass = !m_en || (m_ge ? (v >= m_cmp) : (v < m_cmp));
      @(negedge clk);
      conv_done = 1'b1; conv_result = v;
      @(negedge clk);
      conv_done = 1'b0;
      if (pass && exp_q.size() < 4) exp_q.push_back(v);
   endtask

   // monitor: pops one result from the design and compares with the queue
   task automatic drain_one(string req);
      logic [7:0] hi, lo;
      logic [11:0] e;
      rd(8'h15, hi);
      rd(8'h16, lo);
      e = exp_q.pop_front();
      chk(req, {hi[3:0], lo}, e);
   endtask

   task automatic status(string req, logic [7:0] e);
      logic [7:0] s;
      rd(8'h11, s);
      chk(req, s, e);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
   end

   initial begin
      logic [7:0] d;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      status("R1 status", 8'h08);
      rd(8'h13, d); chk("R1 cmp hi", d, 8'h00);
      rd(8'h14, d); chk("R1 cmp lo", d, 8'h00);

      // R2 read-only bits
      wr(8'h11, 8'hFF);
      status("R2 write ff", 8'h78);
      wr(8'h11, 8'h84);
      status("R2 write 84", 8'h08);

      // R3 software start
      wr(8'h10, 8'h2A);
      chk("R3 start pulse", conv_start, 1'b1);
      chk("R3 channel", conv_chan, 5'h0A);
      @(negedge clk);
      chk("R3 single pulse", conv_start, 1'b0);
      status("R3 active", 8'h88);

      // R6 / R8 completion with compare off
      finish_conv(12'h123);
      status("R6 idle and not empty", 8'h00);
      // R6 done while idle is ignored
      @(negedge clk); conv_done = 1'b1; conv_result = 12'h555;
      @(negedge clk); conv_done = 1'b0;

      // R7 abort
      wr(8'h10, 8'h03);
      wr(8'h10, 8'h03);
      chk("R7 abort pulse", conv_abort, 1'b1);
      status("R7 inactive", 8'h00);
      @(negedge clk); conv_done = 1'b1; conv_result = 12'h777;
      @(negedge clk); conv_done = 1'b0;
      drain_one("R8 R6 R7 only first result kept");
      status("R11 empty again", 8'h08);

      // R9 less-than compare
      wr(8'h13, 8'h02); wr(8'h14, 8'h00); m_cmp = 12'h200;
      set_ctrl(0, 1, 0);
      status("R9 ctrl", 8'h28);
      foreach (exp_q[i]) ;
      wr(8'h10, 0); finish_conv(12'h1FF);
      wr(8'h10, 0); finish_conv(12'h200);
      wr(8'h10, 0); finish_conv(12'h000);
      // R10 greater-or-equal compare
      set_ctrl(0, 1, 1);
      wr(8'h10, 0); finish_conv(12'h200);
      wr(8'h10, 0); finish_conv(12'h1FF);
      wr(8'h10, 0); finish_conv(12'hFFF);
      chk("R9 R10 accepted count", exp_q.size(), 4);
      status("R11 full", 8'h34);
      // R12 overflow drop
      wr(8'h10, 0); finish_conv(12'h300);
      status("R12 still full", 8'h34);
      drain_one("R9 lt 1FF");
      drain_one("R9 lt 000");
      drain_one("R10 ge 200");
      drain_one("R10 R12 ge FFF, 300 dropped");
      status("R11 empty after drain", 8'h38);

      // R4 hardware trigger
      set_ctrl(1, 0, 0);
      wr(8'h10, 8'h05);
      chk("R4 write no start", conv_start, 1'b0);
      status("R4 still idle", 8'h48);
      @(negedge clk); hw_trig = 1'b1;
      @(negedge clk);
      chk("R4 edge start", conv_start, 1'b1);
      chk("R4 hw channel", conv_chan, 5'h05);
      finish_conv(12'h0AB);
      @(negedge clk);
      chk("R4 level no restart", conv_start, 1'b0);
      status("R4 idle after done", 8'h40);
      // R5 trigger while active
      hw_trig = 1'b0;
      @(negedge clk); hw_trig = 1'b1;
      @(negedge clk); chk("R5 second start", conv_start, 1'b1);
      hw_trig = 1'b0;
      @(negedge clk); hw_trig = 1'b1;
      @(negedge clk); chk("R5 busy edge ignored", conv_start, 1'b0);
      status("R5 active", 8'hC0);
      finish_conv(12'h0CD);
      drain_one("R4 hw result");
      drain_one("R5 hw result");
      status("R11 final", 8'h48);

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
   end
endmodule